// File: doc/BRIEF.md
# Decode-Stage Direct Branch Target Checker

This unit sits beside the decode stage of an out-of-order pipeline and looks at every group of instructions that decode hands onward in a cycle. For each slot whose class marks it as a direct unconditional jump, it adds the sign-extended immediate to the slot's PC and compares that target with the one the front-end predictor supplied. A mismatch means the front end fetched down the wrong path. The unit then sends fetch a one-cycle redirect record carrying the corrected next PC and the branch's sequence number. It also removes younger work from the group by sequence number, and only that work.

Slots are examined in slot order, and the lowest mispredicting slot wins. Slots beyond it are not forwarded in that cycle. Any valid slot whose sequence number is larger than the branch's is reported as killed. The branch itself continues downstream. A separate per-slot flag marks a forwarded instruction that the predictor called taken although its class says it is not a control transfer. Two wrapping counters keep the number of targets resolved and the number of redirects raised. All outputs are registered, so results for a group appear one clock after that group is presented.

Top module: `bt_decode_check`

## Requirements
- R1: The computed target of a slot is its PC plus its immediate sign-extended to PC width, modulo 2^PC_W. Only a valid slot with class code 2'b01 (direct unconditional) is resolved. Such a slot mispredicts when the computed target differs from its predicted target. The predicted-taken bit plays no part in that test. Class 2'b00 is not a control transfer; 2'b10 (direct conditional) and 2'b11 (indirect) are never resolved here.
- R2: When a group contains a mispredicting slot, on the next cycle `redir_vld`, `redir_mispred`, `redir_squash` and `redir_taken` are all 1. In the same cycle `redir_seq` holds the branch's sequence number and `redir_pc` holds its computed target.
- R3: Only the lowest-numbered mispredicting slot of a group produces the redirect. Invalid slots never produce one.
- R4: After a redirect, `out_kill[i]` is 1 exactly for valid slots whose sequence number is greater than the branch's, compared unsigned. The branch slot is never killed.
- R5: `out_fwd[i]` is 1 for a valid, non-killed slot at or below the branch slot index. When the group has no mispredicting slot, every valid slot is forwarded and none is killed.
- R6: `out_badpred[i]` is 1 when slot i is forwarded, has class 2'b00 and has its predicted-taken bit set.
- R7: `cnt_resolved` grows by the number of forwarded class-2'b01 slots in each group, wrapping modulo 2^CNT_W.
- R8: `cnt_mispred` grows by exactly one for each group that raises a redirect, and is otherwise unchanged.
- R9: Every output reflects the group presented one cycle earlier. After a cycle with no mispredict, `redir_vld` and its flags are 0, so each redirect lasts one cycle. A cycle with no valid slot yields all-zero per-slot outputs.
- R10: While `rst` is high at a clock edge, every output, including both counters, becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | SLOTS | Slot holds an instruction |
| in_seq | input | SLOTS*SEQ_W | Per-slot sequence number, slot i at [i*SEQ_W +: SEQ_W] |
| in_pc | input | SLOTS*PC_W | Per-slot PC |
| in_imm | input | SLOTS*IMM_W | Per-slot signed immediate offset |
| in_cls | input | SLOTS*2 | Per-slot control class code |
| in_ptk | input | SLOTS | Per-slot predicted-taken bit |
| in_ptgt | input | SLOTS*PC_W | Per-slot predicted target |
| out_fwd | output | SLOTS | Slot forwarded downstream |
| out_kill | output | SLOTS | Slot squashed as younger than the branch |
| out_badpred | output | SLOTS | Non-control slot predicted taken |
| redir_vld | output | 1 | Redirect record valid |
| redir_mispred | output | 1 | Record reports a misprediction |
| redir_squash | output | 1 | Record requests a squash |
| redir_taken | output | 1 | Corrected path is taken |
| redir_seq | output | SEQ_W | Sequence number of the branch |
| redir_pc | output | PC_W | Corrected next PC |
| cnt_resolved | output | CNT_W | Targets resolved |
| cnt_mispred | output | CNT_W | Redirects raised |

## Verification
The assertions assume that `rst` is held for at least two edges at start-up. They also assume that sequence numbers inside one group are distinct and do not wrap, because the young/old test is a plain unsigned compare. The sweep stays within this: each group's sequence base never exceeds 199, and slot offsets add at most 3. The sweep covers every class combination across four slots, with 16 target-mismatch patterns, a range of valid masks and predicted-taken bits. Some groups carry sequence numbers out of slot order, so the kill mask differs from a slot-order flush.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [1:0] {
    CT_NONE     = 2'b00,
    CT_DIR_UNC  = 2'b01,
    CT_DIR_COND = 2'b10,
    CT_INDIRECT = 2'b11
  } ctl_class_e;
endpackage

// File: rtl/bt_slot_eval.sv
module bt_slot_eval
  import bt_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int IMM_W = 8
) (
  input  logic             vld,
  input  logic [PC_W-1:0]  pc,
  input  logic [IMM_W-1:0] imm,
  input  logic [1:0]       cls,
  input  logic             ptk,
  input  logic [PC_W-1:0]  ptgt,
  output logic [PC_W-1:0]  tgt,
  output logic             is_du,
  output logic             miss,
  output logic             nctl_tk
);
  localparam int EXT_W = PC_W - IMM_W;

  ctl_class_e cls_e;
  logic [PC_W-1:0] imm_ext;

  always_comb begin
    cls_e   = ctl_class_e'(cls);
    imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    tgt     = pc + imm_ext;
    is_du   = vld && (cls_e == CT_DIR_UNC);
    miss    = is_du && (tgt != ptgt);
    nctl_tk = vld && (cls_e == CT_NONE) && ptk;
  end
endmodule

// File: rtl/bt_first_pick.sv
module bt_first_pick #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     oh,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    oh  = '0;
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        oh[i] = 1'b1;
        idx   = IDX_W'(i);
        any   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bt_squash_mask.sv
module bt_squash_mask #(
  parameter int N     = 4,
  parameter int SEQ_W = 8
) (
  input  logic [N-1:0]       vld,
  input  logic [N*SEQ_W-1:0] seq,
  input  logic               hit,
  input  logic [N-1:0]       br_oh,
  input  logic [SEQ_W-1:0]   br_seq,
  output logic [N-1:0]       kill,
  output logic [N-1:0]       fwd
);
  logic past_br;

  always_comb begin
    past_br = 1'b0;
    kill    = '0;
    fwd     = '0;
    for (int i = 0; i < N; i++) begin
      kill[i] = hit && vld[i] && (seq[i*SEQ_W +: SEQ_W] > br_seq);
      fwd[i]  = vld[i] && !kill[i] && !(hit && past_br);
      past_br = past_br | br_oh[i];
    end
  end
endmodule

// File: rtl/bt_counters.sv
module bt_counters #(
  parameter int N     = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     du_fwd,
  input  logic             miss_evt,
  output logic [CNT_W-1:0] cnt_res,
  output logic [CNT_W-1:0] cnt_mis
);
  logic [CNT_W-1:0] inc;

  always_comb begin
    inc = '0;
    for (int i = 0; i < N; i++) inc = inc + CNT_W'(du_fwd[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_res <= '0;
      cnt_mis <= '0;
    end else begin
      cnt_res <= cnt_res + inc;
      if (miss_evt) cnt_mis <= cnt_mis + CNT_W'(1);
    end
  end

  p_mis_step_r8: assert property (@(posedge clk) disable iff (rst)
    miss_evt |=> cnt_mis == $past(cnt_mis) + CNT_W'(1));
  p_mis_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !miss_evt |=> $stable(cnt_mis));
  p_res_bound_r7: assert property (@(posedge clk) disable iff (rst)
    (|du_fwd) |=> (cnt_res - $past(cnt_res)) <= CNT_W'(N));
endmodule

// File: rtl/bt_decode_check.sv
module bt_decode_check #(
  parameter int SLOTS = 4,
  parameter int SEQ_W = 8,
  parameter int PC_W  = 16,
  parameter int IMM_W = 8,
  parameter int CNT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [SLOTS-1:0]       in_vld,
  input  logic [SLOTS*SEQ_W-1:0] in_seq,
  input  logic [SLOTS*PC_W-1:0]  in_pc,
  input  logic [SLOTS*IMM_W-1:0] in_imm,
  input  logic [SLOTS*2-1:0]     in_cls,
  input  logic [SLOTS-1:0]       in_ptk,
  input  logic [SLOTS*PC_W-1:0]  in_ptgt,
  output logic [SLOTS-1:0]       out_fwd,
  output logic [SLOTS-1:0]       out_kill,
  output logic [SLOTS-1:0]       out_badpred,
  output logic                   redir_vld,
  output logic                   redir_mispred,
  output logic                   redir_squash,
  output logic                   redir_taken,
  output logic [SEQ_W-1:0]       redir_seq,
  output logic [PC_W-1:0]        redir_pc,
  output logic [CNT_W-1:0]       cnt_resolved,
  output logic [CNT_W-1:0]       cnt_mispred
);
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SLOTS-1:0]      is_du, miss, nctl_tk;
  logic [SLOTS*PC_W-1:0] tgt_flat;
  logic [SLOTS-1:0]      first_oh;
  logic                  hit;
  logic [IDX_W-1:0]      first_idx;
  logic [SEQ_W-1:0]      br_seq;
  logic [PC_W-1:0]       br_tgt;
  logic [SLOTS-1:0]      kill_c, fwd_c;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    bt_slot_eval #(.PC_W(PC_W), .IMM_W(IMM_W)) u_eval (
      .vld    (in_vld[g]),
      .pc     (in_pc[g*PC_W +: PC_W]),
      .imm    (in_imm[g*IMM_W +: IMM_W]),
      .cls    (in_cls[g*2 +: 2]),
      .ptk    (in_ptk[g]),
      .ptgt   (in_ptgt[g*PC_W +: PC_W]),
      .tgt    (tgt_flat[g*PC_W +: PC_W]),
      .is_du  (is_du[g]),
      .miss   (miss[g]),
      .nctl_tk(nctl_tk[g])
    );
  end

  bt_first_pick #(.N(SLOTS)) u_pick (
    .req(miss),
    .oh (first_oh),
    .any(hit),
    .idx(first_idx)
  );

  always_comb begin
    br_seq = in_seq[int'(first_idx)*SEQ_W +: SEQ_W];
    br_tgt = tgt_flat[int'(first_idx)*PC_W +: PC_W];
  end

  bt_squash_mask #(.N(SLOTS), .SEQ_W(SEQ_W)) u_mask (
    .vld   (in_vld),
    .seq   (in_seq),
    .hit   (hit),
    .br_oh (first_oh),
    .br_seq(br_seq),
    .kill  (kill_c),
    .fwd   (fwd_c)
  );

  bt_counters #(.N(SLOTS), .CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .du_fwd  (is_du & fwd_c),
    .miss_evt(hit),
    .cnt_res (cnt_resolved),
    .cnt_mis (cnt_mispred)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_fwd       <= '0;
      out_kill      <= '0;
      out_badpred   <= '0;
      redir_vld     <= 1'b0;
      redir_mispred <= 1'b0;
      redir_squash  <= 1'b0;
      redir_taken   <= 1'b0;
      redir_seq     <= '0;
      redir_pc      <= '0;
    end else begin
      out_fwd       <= fwd_c;
      out_kill      <= kill_c;
      out_badpred   <= nctl_tk & fwd_c;
      redir_vld     <= hit;
      redir_mispred <= hit;
      redir_squash  <= hit;
      redir_taken   <= hit;
      redir_seq     <= hit ? br_seq : '0;
      redir_pc      <= hit ? br_tgt : '0;
    end
  end

  p_first_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(first_oh));
  p_redir_fields_r2: assert property (@(posedge clk) disable iff (rst)
    redir_vld |-> (redir_mispred && redir_squash && redir_taken));
  p_kill_needs_redir_r4: assert property (@(posedge clk) disable iff (rst)
    (|out_kill) |-> redir_vld);
  p_kill_fwd_excl_r5: assert property (@(posedge clk) disable iff (rst)
    (out_kill & out_fwd) == '0);
  p_fwd_from_valid_r9: assert property (@(posedge clk) disable iff (rst)
    (in_vld == '0) |=> (out_fwd == '0 && !redir_vld));
  p_badpred_fwd_r6: assert property (@(posedge clk) disable iff (rst)
    (out_badpred & ~out_fwd) == '0);
endmodule

// File: tb/bt_decode_check_tb_top.sv
`timescale 1ns/1ps
module bt_decode_check_tb_top;
  localparam int SLOTS = 4;
  localparam int SEQ_W = 8;
  localparam int PC_W  = 16;
  localparam int IMM_W = 8;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [SLOTS-1:0]       in_vld = '0;
  logic [SLOTS*SEQ_W-1:0] in_seq = '0;
  logic [SLOTS*PC_W-1:0]  in_pc = '0;
  logic [SLOTS*IMM_W-1:0] in_imm = '0;
  logic [SLOTS*2-1:0]     in_cls = '0;
  logic [SLOTS-1:0]       in_ptk = '0;
  logic [SLOTS*PC_W-1:0]  in_ptgt = '0;
  logic [SLOTS-1:0]       out_fwd, out_kill, out_badpred;
  logic redir_vld, redir_mispred, redir_squash, redir_taken;
  logic [SEQ_W-1:0] redir_seq;
  logic [PC_W-1:0]  redir_pc;
  logic [CNT_W-1:0] cnt_resolved, cnt_mispred;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  logic [SLOTS-1:0] e_fwd, e_kill, e_bad;
  logic e_rv;
  logic [SEQ_W-1:0] e_seq;
  logic [PC_W-1:0]  e_pc;
  logic [CNT_W-1:0] e_res = '0;
  logic [CNT_W-1:0] e_mis = '0;

  always #4 clk = ~clk;

  bt_decode_check dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_seq(in_seq), .in_pc(in_pc),
    .in_imm(in_imm), .in_cls(in_cls), .in_ptk(in_ptk), .in_ptgt(in_ptgt),
    .out_fwd(out_fwd), .out_kill(out_kill), .out_badpred(out_badpred),
    .redir_vld(redir_vld), .redir_mispred(redir_mispred),
    .redir_squash(redir_squash), .redir_taken(redir_taken),
    .redir_seq(redir_seq), .redir_pc(redir_pc),
    .cnt_resolved(cnt_resolved), .cnt_mispred(cnt_mispred)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int perm_off(input int i);
    case (i)
      0: return 2;
      1: return 0;
      2: return 3;
      default: return 1;
    endcase
  endfunction

  // Drive group g and compute the expected response (R1, R3..R8).
  task automatic drive_group(input int g);
    logic [11:0] gb;
    logic [SEQ_W-1:0] sq [SLOTS];
    logic [PC_W-1:0] pc, tg;
    logic [IMM_W-1:0] im;
    logic [1:0] cl;
    logic [SLOTS-1:0] du;
    int first;
    gb = 12'(g);
    in_cls = gb[7:0];
    in_vld = (g % 5 == 0) ? (gb[3:0] ^ gb[11:8]) : 4'hF;
    in_ptk = gb[11:8] ^ gb[5:2];
    first = -1;
    du = '0;
    for (int i = 0; i < SLOTS; i++) begin
      sq[i] = SEQ_W'((g % 200) + ((g % 7 == 3) ? perm_off(i) : i));
      pc = PC_W'(g * 13 + i * 4);
      im = IMM_W'(g * 7 + i * 37);
      tg = pc + {{(PC_W-IMM_W){im[IMM_W-1]}}, im};
      cl = gb[i*2 +: 2];
      in_seq[i*SEQ_W +: SEQ_W] = sq[i];
      in_pc[i*PC_W +: PC_W] = pc;
      in_imm[i*IMM_W +: IMM_W] = im;
      in_ptgt[i*PC_W +: PC_W] = tg ^ PC_W'(gb[8 + i]);
      du[i] = in_vld[i] && (cl == 2'b01);
      if (du[i] && gb[8 + i] && first < 0) begin
        first = i;
        e_seq = sq[i];
        e_pc  = tg;
      end
    end
    e_rv = (first >= 0);
    if (!e_rv) begin
      e_seq = '0;
      e_pc  = '0;
    end
    for (int i = 0; i < SLOTS; i++) begin
      e_kill[i] = e_rv && in_vld[i] && (sq[i] > e_seq);
      e_fwd[i]  = in_vld[i] && !e_kill[i] && (!e_rv || i <= first);
      e_bad[i]  = e_fwd[i] && (gb[i*2 +: 2] == 2'b00) && in_ptk[i];
      if (e_fwd[i] && du[i]) e_res = e_res + CNT_W'(1);
    end
    if (e_rv) e_mis = e_mis + CNT_W'(1);
  endtask

  task automatic check_group();
    chk(out_fwd == e_fwd, "R5 fwd", 64'(out_fwd), 64'(e_fwd));
    chk(out_kill == e_kill, "R4 kill", 64'(out_kill), 64'(e_kill));
    chk(out_badpred == e_bad, "R6 badpred", 64'(out_badpred), 64'(e_bad));
    chk(redir_vld == e_rv && redir_mispred == e_rv && redir_squash == e_rv &&
        redir_taken == e_rv, "R2/R3/R9 redirect flags",
        64'({redir_vld, redir_mispred, redir_squash, redir_taken}),
        64'({4{e_rv}}));
    if (e_rv) begin
      chk(redir_seq == e_seq, "R2 seq", 64'(redir_seq), 64'(e_seq));
      chk(redir_pc == e_pc, "R1 target", 64'(redir_pc), 64'(e_pc));
    end
    chk(cnt_resolved == e_res, "R7 resolved", 64'(cnt_resolved), 64'(e_res));
    chk(cnt_mispred == e_mis, "R8 mispred", 64'(cnt_mispred), 64'(e_mis));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk({out_fwd, out_kill, out_badpred} == '0, "R10 slot outputs",
        64'({out_fwd, out_kill, out_badpred}), 64'(0));
    chk(!redir_vld && redir_pc == '0 && redir_seq == '0, "R10 redirect",
        64'({redir_vld, redir_seq, redir_pc}), 64'(0));
    chk(cnt_resolved == '0 && cnt_mispred == '0, "R10 counters",
        64'({cnt_resolved, cnt_mispred}), 64'(0));
    rst = 1'b0;
    for (int g = 0; g < 4096; g++) begin
      drive_group(g);
      @(negedge clk);
      check_group();
    end
    // R9: idle group produces nothing, redirect does not linger
    in_vld = '0;
    @(negedge clk);
    chk(out_fwd == '0 && out_kill == '0 && !redir_vld, "R9 idle",
        64'({out_fwd, out_kill, redir_vld}), 64'(0));
    chk(cnt_mispred == e_mis && cnt_resolved == e_res, "R8 idle hold",
        64'({cnt_resolved, cnt_mispred}), 64'({e_res, e_mis}));
    // R10: reset mid-run clears counters
    rst = 1'b1;
    @(negedge clk);
    chk(cnt_resolved == '0 && cnt_mispred == '0 && !redir_vld, "R10 rerun",
        64'({cnt_resolved, cnt_mispred}), 64'(0));
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule